// File: doc/BRIEF.md
# CAN Transmit Buffer Arbiter

This block chooses which of a set of transmit message buffers a CAN-style controller sends next. It does not arbitrate all the time. A new choice is made only at fixed points: while the CRC field of the current frame is on the bus, during an error delimiter, when freeze mode is left, and when the CPU writes a buffer's control word while the bus is idle or bus-off. During intermission a choice is made again only if one is owed. One is owed when the previous winner was withdrawn, or when the last choice found nothing and the CPU has written a control word since then. Among the buffers whose control code marks them ready to send, the lowest index wins. The winner is then copied ("moved out") into a shadow transmit register, and the bus engine sends from that copy.

A behavioural bus engine stands in for the serializer. It pulses `id_start_i` when the identifier begins and `tx_done_i` when the frame has been sent without error. On that pulse the block does four things for the buffer that was sent. It writes the timer value captured at the identifier start into the buffer's timestamp, sets the buffer's code back to transmit-inactive, and sets the buffer's completion flag. The interrupt output is raised only if the buffer's mask bit is set.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset every buffer code is 4'b0000, every flag is 0, `irq_o` is 0 and `tx_vld_o` is 0.
- R2: A pulse on `cs_wr_i[i]` loads `cs_code_i` into the code of buffer i.
- R3: An arbitration starts on `ph_crc_i`, `ph_errdelim_i` or `freeze_exit_i`. A buffer made ready while no trigger occurs is not moved out.
- R4: A pulse on `ph_inter_i` starts an arbitration only when one is owed. One is owed when the winner was withdrawn, or when the last arbitration found no candidate and a control word was written afterwards. Otherwise the pulse does nothing.
- R5: While `bus_idle_i` is high, a control-word write to any buffer starts an arbitration, and that arbitration sees the value just written.
- R6: Only buffers with code 4'b1100 that are not already in the shadow register are candidates. The lowest index wins.
- R7: Move-out copies the winner's index, identifier and length into the shadow register. The shadow register holds these values until `tx_done_i`, even if the buffer's inputs change.
- R8: A length above 8 appears on `tx_dlc_o` as 8. Lengths of 8 or below pass unchanged.
- R9: On `tx_done_i`, the sent buffer gets code 4'b1000, its flag is set, and its timestamp becomes the free-running timer value at the last `id_start_i`. The timer counts clock cycles from 0 after reset.
- R10: `irq_o` is high exactly when some buffer has both its flag and its `irq_mask_i` bit set.
- R11: A 1 on `flag_clr_i[i]` clears flag i. A 0 leaves the flag as it is.
- R12: A control-word write to the held winner before move-out cancels that winner. Nothing is moved out until a later arbitration, and an intermission arbitration becomes owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ph_crc_i | input | 1 | Bus is in the CRC field |
| ph_errdelim_i | input | 1 | Bus is in an error delimiter |
| ph_inter_i | input | 1 | Bus is in intermission |
| bus_idle_i | input | 1 | Bus idle or bus-off (level) |
| freeze_exit_i | input | 1 | Pulse when freeze mode is left |
| cs_wr_i | input | N | Per-buffer control-word write strobe |
| cs_code_i | input | 4 | Code value written with the strobe |
| mb_id_i | input | N*ID_W | Identifier of each buffer |
| mb_dlc_i | input | N*DLC_W | Length code of each buffer |
| id_start_i | input | 1 | Identifier field of the sent frame begins |
| tx_done_i | input | 1 | Shadow frame sent successfully |
| flag_clr_i | input | N | Write-1-to-clear for completion flags |
| irq_mask_i | input | N | Per-buffer interrupt enable |
| mb_code_o | output | N*4 | Code of each buffer |
| mb_ts_o | output | N*TS_W | Timestamp of each buffer |
| flag_o | output | N | Completion flags |
| irq_o | output | 1 | Masked interrupt |
| tx_vld_o | output | 1 | Shadow register holds a frame |
| tx_idx_o | output | IW | Index of the buffer in the shadow register |
| tx_id_o | output | ID_W | Shadow identifier |
| tx_dlc_o | output | DLC_W | Shadow length, capped at 8 |

## Verification
The bench withdraws a winner while the shadow register is still busy. A design that ignored the write would move out a buffer the CPU has already withdrawn. A design that dropped the owed re-arbitration would never send the buffer again after intermission. It also pulses intermission with nothing owed, which catches a design that arbitrates on every intermission. Further cases are an all-ready pattern, an empty pattern and length codes above 8, which expose wrong priority order and an uncapped length. Changing a buffer's identifier after move-out shows whether the shadow register really holds a snapshot.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] MBC_RX_OFF   = 4'b0000;
    localparam logic [CODE_W-1:0] MBC_RX_EMPTY = 4'b0100;
    localparam logic [CODE_W-1:0] MBC_TX_OFF   = 4'b1000;
    localparam logic [CODE_W-1:0] MBC_TX_SEND  = 4'b1100;
    localparam int MAX_PAYLOAD = 8;
endpackage

// File: rtl/mb_prio_pick.sv
module mb_prio_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  gnt_o
);
    logic [N-1:0] below;

    assign below[0] = 1'b0;
    for (genvar g = 1; g < N; g++) begin : g_chain
        assign below[g] = below[g-1] | req_i[g-1];
    end

    assign gnt_o = req_i & ~below;
    assign vld_o = |req_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_o[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/arb_trigger.sv
module arb_trigger #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph_crc_i,
    input  logic         ph_errdelim_i,
    input  logic         ph_inter_i,
    input  logic         bus_idle_i,
    input  logic         freeze_exit_i,
    input  logic [N-1:0] cs_wr_i,
    input  logic         win_kill_i,
    input  logic         arb_none_i,
    output logic         go_o,
    output logic         pend_o
);
    typedef struct packed {
        logic go;
        logic pend;
        logic none;
    } trig_t;

    trig_t st_q, st_d;
    logic  any_wr;

    always_comb begin
        any_wr  = |cs_wr_i;
        st_d    = st_q;
        st_d.go = ph_crc_i | ph_errdelim_i | freeze_exit_i
                | (bus_idle_i & any_wr)
                | (ph_inter_i & st_q.pend);
        st_d.pend = win_kill_i | (st_q.none & any_wr) | (st_q.pend & ~st_q.go);
        if (st_q.go) st_d.none = arb_none_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{go: 1'b0, pend: 1'b0, none: 1'b1};
        else        st_q <= st_d;
    end

    assign go_o   = st_q.go;
    assign pend_o = st_q.pend;

    // R4
    inter_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && !ph_crc_i && !ph_errdelim_i && !freeze_exit_i && !bus_idle_i)
        |=> !st_q.go);

    // R5
    idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle_i && (cs_wr_i != '0)) |=> st_q.go);
endmodule

// File: rtl/mb_status.sv
module mb_status
    import can_arb_pkg::*;
#(
    parameter int N    = 8,
    parameter int TS_W = 16,
    parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        cs_wr_i,
    input  logic [CODE_W-1:0]   cs_code_i,
    input  logic                done_i,
    input  logic [IW-1:0]       done_idx_i,
    input  logic [TS_W-1:0]     done_ts_i,
    input  logic [N-1:0]        flag_clr_i,
    output logic [N*CODE_W-1:0] code_o,
    output logic [N*TS_W-1:0]   ts_o,
    output logic [N-1:0]        flag_o
);
    typedef struct packed {
        logic [N-1:0][CODE_W-1:0] code;
        logic [N-1:0][TS_W-1:0]   ts;
        logic [N-1:0]             flag;
    } stat_t;

    stat_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (done_i && done_idx_i == IW'(i)) begin
                st_d.code[i] = MBC_TX_OFF;
                st_d.ts[i]   = done_ts_i;
                st_d.flag[i] = 1'b1;
            end else if (flag_clr_i[i]) begin
                st_d.flag[i] = 1'b0;
            end
            if (cs_wr_i[i]) st_d.code[i] = cs_code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign ts_o   = st_q.ts;
    assign flag_o = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R11
        flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr_i[g] && !(done_i && done_idx_i == IW'(g))) |=> !st_q.flag[g]);
        // R2
        code_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cs_wr_i[g] |=> st_q.code[g] == $past(cs_code_i));
        // R9
        done_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && done_idx_i == IW'(g) && !cs_wr_i[g])
            |=> (st_q.code[g] == MBC_TX_OFF) && st_q.flag[g]);
    end
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
    import can_arb_pkg::*;
#(
    parameter int N     = 8,
    parameter int ID_W  = 11,
    parameter int DLC_W = 4,
    parameter int TS_W  = 16,
    parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ph_crc_i,
    input  logic                ph_errdelim_i,
    input  logic                ph_inter_i,
    input  logic                bus_idle_i,
    input  logic                freeze_exit_i,
    input  logic [N-1:0]        cs_wr_i,
    input  logic [CODE_W-1:0]   cs_code_i,
    input  logic [N*ID_W-1:0]   mb_id_i,
    input  logic [N*DLC_W-1:0]  mb_dlc_i,
    input  logic                id_start_i,
    input  logic                tx_done_i,
    input  logic [N-1:0]        flag_clr_i,
    input  logic [N-1:0]        irq_mask_i,
    output logic [N*CODE_W-1:0] mb_code_o,
    output logic [N*TS_W-1:0]   mb_ts_o,
    output logic [N-1:0]        flag_o,
    output logic                irq_o,
    output logic                tx_vld_o,
    output logic [IW-1:0]       tx_idx_o,
    output logic [ID_W-1:0]     tx_id_o,
    output logic [DLC_W-1:0]    tx_dlc_o
);
    localparam logic [DLC_W-1:0] LEN_CAP = DLC_W'(MAX_PAYLOAD);

    typedef struct packed {
        logic [TS_W-1:0]  timer;
        logic [TS_W-1:0]  ts_cap;
        logic             win_vld;
        logic [IW-1:0]    win_idx;
        logic             sh_vld;
        logic [IW-1:0]    sh_idx;
        logic [ID_W-1:0]  sh_id;
        logic [DLC_W-1:0] sh_dlc;
    } core_t;

    core_t st_q, st_d;

    logic [N*CODE_W-1:0] code_flat;
    logic [N-1:0]        flag_vec;
    logic [N-1:0]        cand;
    logic                pick_vld;
    logic [IW-1:0]       pick_idx;
    logic [N-1:0]        pick_gnt;
    logic                go;
    logic                pend;
    logic                win_kill;
    logic                move_out;
    logic                done;
    logic [DLC_W-1:0]    dlc_sel;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cand[i] = (code_flat[i*CODE_W +: CODE_W] == MBC_TX_SEND)
                   && !(st_q.sh_vld && st_q.sh_idx == IW'(i));
        end
    end

    mb_prio_pick #(.N(N), .IW(IW)) u_pick (
        .req_i (cand),
        .vld_o (pick_vld),
        .idx_o (pick_idx),
        .gnt_o (pick_gnt)
    );

    assign win_kill = st_q.win_vld & cs_wr_i[st_q.win_idx];

    arb_trigger #(.N(N)) u_trig (
        .clk           (clk),
        .rst_n         (rst_n),
        .ph_crc_i      (ph_crc_i),
        .ph_errdelim_i (ph_errdelim_i),
        .ph_inter_i    (ph_inter_i),
        .bus_idle_i    (bus_idle_i),
        .freeze_exit_i (freeze_exit_i),
        .cs_wr_i       (cs_wr_i),
        .win_kill_i    (win_kill),
        .arb_none_i    (~pick_vld),
        .go_o          (go),
        .pend_o        (pend)
    );

    always_comb begin
        st_d       = st_q;
        st_d.timer = st_q.timer + 1'b1;
        done       = tx_done_i & st_q.sh_vld;
        move_out   = st_q.win_vld & ~st_q.sh_vld & ~win_kill & ~go;
        dlc_sel    = mb_dlc_i[st_q.win_idx*DLC_W +: DLC_W];

        if (id_start_i && st_q.sh_vld) st_d.ts_cap = st_q.timer;

        if (win_kill) st_d.win_vld = 1'b0;

        if (move_out) begin
            st_d.win_vld = 1'b0;
            st_d.sh_vld  = 1'b1;
            st_d.sh_idx  = st_q.win_idx;
            st_d.sh_id   = mb_id_i[st_q.win_idx*ID_W +: ID_W];
            st_d.sh_dlc  = (dlc_sel > LEN_CAP) ? LEN_CAP : dlc_sel;
        end

        if (go) begin
            st_d.win_vld = pick_vld;
            st_d.win_idx = pick_idx;
        end

        if (done) st_d.sh_vld = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mb_status #(.N(N), .TS_W(TS_W), .IW(IW)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_wr_i    (cs_wr_i),
        .cs_code_i  (cs_code_i),
        .done_i     (done),
        .done_idx_i (st_q.sh_idx),
        .done_ts_i  (st_q.ts_cap),
        .flag_clr_i (flag_clr_i),
        .code_o     (code_flat),
        .ts_o       (mb_ts_o),
        .flag_o     (flag_vec)
    );

    assign mb_code_o = code_flat;
    assign flag_o    = flag_vec;
    assign irq_o     = |(flag_vec & irq_mask_i);
    assign tx_vld_o  = st_q.sh_vld;
    assign tx_idx_o  = st_q.sh_idx;
    assign tx_id_o   = st_q.sh_id;
    assign tx_dlc_o  = st_q.sh_dlc;

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_gnt));

    // R6
    win_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && pick_vld) |-> code_flat[pick_idx*CODE_W +: CODE_W] == MBC_TX_SEND);

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sh_vld && !tx_done_i) |=> st_q.sh_vld && $stable(st_q.sh_idx)
                                      && $stable(st_q.sh_id) && $stable(st_q.sh_dlc));

    // R8
    dlc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sh_vld |-> st_q.sh_dlc <= LEN_CAP);

    // R12
    winner_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.win_vld && cs_wr_i[st_q.win_idx] && !go) |=> !st_q.win_vld && pend);
endmodule

// File: tb/tb_can_tx_arbiter.sv
module tb_can_tx_arbiter;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ph_crc = 0, ph_errdelim = 0, ph_inter = 0, bus_idle = 0, freeze_exit = 0;
    logic [N-1:0]  cs_wr = '0;
    logic [3:0]    cs_code = '0;
    logic [N*11-1:0] mb_id;
    logic [N*4-1:0]  mb_dlc;
    logic          id_start = 0, tx_done = 0;
    logic [N-1:0]  flag_clr = '0, irq_mask = '0;
    logic [N*4-1:0]  mb_code;
    logic [N*16-1:0] mb_ts;
    logic [N-1:0]  flag;
    logic          irq, tx_vld;
    logic [2:0]    tx_idx;
    logic [10:0]   tx_id;
    logic [3:0]    tx_dlc;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [15:0] tb_cyc;

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) tb_cyc <= '0;
        else        tb_cyc <= tb_cyc + 16'd1;

    can_tx_arbiter dut (
        .clk(clk), .rst_n(rst_n), .ph_crc_i(ph_crc), .ph_errdelim_i(ph_errdelim),
        .ph_inter_i(ph_inter), .bus_idle_i(bus_idle), .freeze_exit_i(freeze_exit),
        .cs_wr_i(cs_wr), .cs_code_i(cs_code), .mb_id_i(mb_id), .mb_dlc_i(mb_dlc),
        .id_start_i(id_start), .tx_done_i(tx_done), .flag_clr_i(flag_clr),
        .irq_mask_i(irq_mask), .mb_code_o(mb_code), .mb_ts_o(mb_ts), .flag_o(flag),
        .irq_o(irq), .tx_vld_o(tx_vld), .tx_idx_o(tx_idx), .tx_id_o(tx_id), .tx_dlc_o(tx_dlc)
    );

    typedef struct packed {
        logic [7:0] act;
        logic       vld;
        logic [2:0] idx;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h80, 1'b1, 3'd7},
        '{8'h16, 1'b1, 3'd1},
        '{8'h00, 1'b0, 3'd0},
        '{8'hFF, 1'b1, 3'd0},
        '{8'h50, 1'b1, 3'd4},
        '{8'h0C, 1'b1, 3'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_write(input int idx, input logic [3:0] code);
        @(negedge clk);
        cs_wr = '0;
        cs_wr[idx] = 1'b1;
        cs_code = code;
        @(negedge clk);
        cs_wr = '0;
    endtask

    task automatic set_all(input logic [7:0] act);
        for (int i = 0; i < N; i++)
            cs_write(i, act[i] ? 4'hC : ((i % 2 == 1) ? 4'h4 : 4'h8));
    endtask

    task automatic pulse_crc();    @(negedge clk); ph_crc = 1;      @(negedge clk); ph_crc = 0;      endtask
    task automatic pulse_inter();  @(negedge clk); ph_inter = 1;    @(negedge clk); ph_inter = 0;    endtask
    task automatic pulse_done();   @(negedge clk); tx_done = 1;     @(negedge clk); tx_done = 0;     endtask

    task automatic finish_tx(input int idx);
        logic [15:0] exp_ts;
        @(negedge clk);
        id_start = 1;
        exp_ts = tb_cyc;
        @(negedge clk);
        id_start = 0;
        cyc(3);
        pulse_done();
        cyc(1);
        chk("R9 code", 32'(mb_code[idx*4 +: 4]), 32'h8);
        chk("R9 timestamp", 32'(mb_ts[idx*16 +: 16]), 32'(exp_ts));
        chk("R9 flag", 32'(flag[idx]), 32'h1);
        chk("R9 shadow freed", 32'(tx_vld), 32'h0);
    endtask

    task automatic clr_flags(input logic [7:0] m);
        @(negedge clk); flag_clr = m; @(negedge clk); flag_clr = '0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mb_id[i*11 +: 11] = 11'h100 + 11'(i);
            mb_dlc[i*4 +: 4]  = 4'(i);
        end
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 codes", mb_code, 32'h0);
        chk("R1 flags", 32'(flag), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 tx_vld", 32'(tx_vld), 32'h0);

        // R2 control-word write
        cs_write(3, 4'h8);
        chk("R2 code write", 32'(mb_code[12 +: 4]), 32'h8);

        // R6 / R3: priority table triggered by the CRC phase
        foreach (VECS[v]) begin
            set_all(VECS[v].act);
            pulse_crc();
            cyc(4);
            chk("R6 valid", 32'(tx_vld), 32'(VECS[v].vld));
            if (VECS[v].vld) begin
                chk("R6 index", 32'(tx_idx), 32'(VECS[v].idx));
                chk("R7 id", 32'(tx_id), 32'h100 + 32'(VECS[v].idx));
                chk("R8 small length", 32'(tx_dlc), 32'(VECS[v].idx));
                finish_tx(int'(VECS[v].idx));
                clr_flags(8'h1 << VECS[v].idx);
                chk("R11 clear", 32'(flag), 32'h0);
            end
        end

        // R3 error delimiter trigger
        set_all(8'h20);
        @(negedge clk); ph_errdelim = 1; @(negedge clk); ph_errdelim = 0;
        cyc(4);
        chk("R3 errdelim index", {28'h0, tx_vld, tx_idx}, {28'h0, 1'b1, 3'd5});
        finish_tx(5);
        // R3 freeze exit trigger
        set_all(8'h04);
        @(negedge clk); freeze_exit = 1; @(negedge clk); freeze_exit = 0;
        cyc(4);
        chk("R3 freeze index", {28'h0, tx_vld, tx_idx}, {28'h0, 1'b1, 3'd2});
        finish_tx(2);
        // R3 no trigger, no move-out
        set_all(8'h08);
        cyc(6);
        chk("R3 untriggered", 32'(tx_vld), 32'h0);
        pulse_crc();
        cyc(4);
        chk("R3 crc index", {28'h0, tx_vld, tx_idx}, {28'h0, 1'b1, 3'd3});
        finish_tx(3);
        clr_flags(8'hFF);

        // R5 idle write triggers arbitration
        set_all(8'h00);
        @(negedge clk); bus_idle = 1;
        cs_write(6, 4'hC);
        cyc(4);
        chk("R5 idle index", {28'h0, tx_vld, tx_idx}, {28'h0, 1'b1, 3'd6});
        @(negedge clk); bus_idle = 0;
        finish_tx(6);

        // R4 intermission without anything owed
        set_all(8'h10);
        pulse_crc();
        cyc(4);
        finish_tx(4);
        cs_write(1, 4'hC);
        pulse_inter();
        cyc(4);
        chk("R4 quiet intermission", 32'(tx_vld), 32'h0);
        // R4 owed after an empty arbitration and a later write
        cs_write(1, 4'h8);
        pulse_crc();
        cyc(4);
        cs_write(1, 4'hC);
        pulse_inter();
        cyc(4);
        chk("R4 owed intermission", {28'h0, tx_vld, tx_idx}, {28'h0, 1'b1, 3'd1});
        finish_tx(1);
        clr_flags(8'hFF);

        // R12 withdrawn winner
        set_all(8'h01);
        pulse_crc();
        cyc(4);
        cs_write(2, 4'hC);
        pulse_crc();
        cyc(4);
        cs_write(2, 4'h8);
        pulse_done();
        cyc(4);
        chk("R12 no move-out", 32'(tx_vld), 32'h0);
        cs_write(2, 4'hC);
        cyc(4);
        chk("R12 still idle", 32'(tx_vld), 32'h0);
        pulse_inter();
        cyc(4);
        chk("R12 rearbitrated", {28'h0, tx_vld, tx_idx}, {28'h0, 1'b1, 3'd2});
        finish_tx(2);
        clr_flags(8'hFF);

        // R8 / R7 length cap and snapshot
        @(negedge clk);
        mb_id[5*11 +: 11] = 11'h5A5;
        mb_dlc[5*4 +: 4]  = 4'd13;
        set_all(8'h20);
        pulse_crc();
        cyc(4);
        chk("R8 capped length", 32'(tx_dlc), 32'h8);
        chk("R7 id copied", 32'(tx_id), 32'h5A5);
        @(negedge clk);
        mb_id[5*11 +: 11] = 11'h123;
        mb_dlc[5*4 +: 4]  = 4'd2;
        cyc(3);
        chk("R7 id snapshot", 32'(tx_id), 32'h5A5);
        chk("R7 length snapshot", 32'(tx_dlc), 32'h8);
        finish_tx(5);

        // R10 masked interrupt, R11 write-1-to-clear
        @(negedge clk); irq_mask = 8'h00;
        cyc(1);
        chk("R10 masked off", 32'(irq), 32'h0);
        @(negedge clk); irq_mask = 8'h10;
        cyc(1);
        chk("R10 other mask bit", 32'(irq), 32'h0);
        @(negedge clk); irq_mask = 8'h20;
        cyc(1);
        chk("R10 enabled", 32'(irq), 32'h1);
        clr_flags(8'hDF);
        chk("R11 zero bit keeps flag", 32'(flag), 32'h20);
        clr_flags(8'h20);
        chk("R11 one bit clears flag", 32'(flag), 32'h0);
        chk("R10 irq drops", 32'(irq), 32'h0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule